// File: doc/BRIEF.md
# Dual Column Step Sequencer

This block paces two compute columns that advance a shared simulation in lock-step time steps but need different numbers of cycles to finish each step. It clears both columns once at the start of a run, then for each step it issues a go pulse, keeps both column clock enables high, and drops each enable as soon as that column reports ready. The faster column is frozen while the slower one catches up.

When both columns have reported, the block spends one settle cycle with both enables low. It then pulses a commit strobe so that each column stores its results in its own memory, counts the step, and either starts the next step or ends the run. The run ends when the step count equals a limit supplied on an input port. The column enables are synchronous clock-enable levels, not gated clocks.

Top module: `dual_column_sequencer`

## Requirements
- R1: After reset every output is low and the step count is zero; the block waits while run_i is low.
- R2: A high run_i in the waiting state gives one cycle with both column resets high and the step count cleared, then one cycle with step_go_o high and both enables high.
- R3: While both columns run, a ready from only column A drops en_a_o and keeps en_b_o high from the next cycle; a ready from only column B does the same with the roles swapped.
- R4: With one column done, the block holds (the other enable high, no commit, count unchanged) until the other column reports ready.
- R5: When both readies arrive in the same cycle, both enables are low from the next cycle.
- R6: Once both columns are done, exactly one settle cycle follows with both enables low and commit_o low, then commit_o is high for exactly one cycle.
- R7: The cycle after a commit, the step count has risen by one and, if it is below step_limit_i, step_go_o is high with both enables high.
- R8: When the step count after a commit equals step_limit_i, run_done_o goes high with both enables low and stays high until run_i goes low, after which the block is waiting again.
- R9: A step_limit_i of zero ends the run right after the clearing cycle with no go pulse and a count of zero.
- R10: Ready inputs are ignored during the clearing and go cycles; a column whose ready is already high keeps its enable high in the cycle after the go pulse and loses it one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Request a run; drop after run_done_o to return to waiting |
| step_limit_i | input | STEP_W | Number of steps in a run, held stable during the run |
| rdy_a_i | input | 1 | Column A has finished the current step |
| rdy_b_i | input | 1 | Column B has finished the current step |
| rst_a_o | output | 1 | Clear for column A |
| rst_b_o | output | 1 | Clear for column B |
| en_a_o | output | 1 | Clock enable for column A |
| en_b_o | output | 1 | Clock enable for column B |
| step_go_o | output | 1 | One-cycle start of a step |
| commit_o | output | 1 | One-cycle strobe to store column results |
| step_cnt_o | output | STEP_W | Steps completed in this run |
| run_done_o | output | 1 | Run has reached the step limit |

## Verification
All outputs are decoded from the state register, so every response shows one clock edge after the input that caused it: the enable drop one edge after a ready, the settle cycle one edge after the last ready, the commit one edge later and the new count and go pulse one edge after that. The bench drives inputs and samples outputs on the falling edge and steps exactly one rising edge between a stimulus and its check, so each check lands in the cycle the requirement names. Holding cases are checked over an extra idle edge to show nothing moved.

// File: rtl/dual_column_sequencer.sv
module dual_column_sequencer #(
  parameter int STEP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic [STEP_W-1:0] step_limit_i,
  input  logic              rdy_a_i,
  input  logic              rdy_b_i,
  output logic              rst_a_o,
  output logic              rst_b_o,
  output logic              en_a_o,
  output logic              en_b_o,
  output logic              step_go_o,
  output logic              commit_o,
  output logic [STEP_W-1:0] step_cnt_o,
  output logic              run_done_o
);

  typedef enum logic [3:0] {
    S_IDLE, S_CLEAR, S_GO, S_RUN, S_A_DONE, S_B_DONE, S_SETTLE, S_COMMIT, S_DONE
  } state_t;

  state_t state, nxt;
  logic [STEP_W-1:0] cnt;
  logic [STEP_W-1:0] cnt_inc;

  assign cnt_inc = cnt + 1'b1;

  always_comb begin
    nxt = state;
    case (state)
      S_IDLE:   if (run_i) nxt = S_CLEAR;
      S_CLEAR:  nxt = (step_limit_i == '0) ? S_DONE : S_GO;
      S_GO:     nxt = S_RUN;
      S_RUN: begin
        if (rdy_a_i && rdy_b_i) nxt = S_SETTLE;
        else if (rdy_a_i)       nxt = S_A_DONE;
        else if (rdy_b_i)       nxt = S_B_DONE;
      end
      S_A_DONE: if (rdy_b_i) nxt = S_SETTLE;
      S_B_DONE: if (rdy_a_i) nxt = S_SETTLE;
      S_SETTLE: nxt = S_COMMIT;
      S_COMMIT: nxt = (cnt_inc == step_limit_i) ? S_DONE : S_GO;
      S_DONE:   if (!run_i) nxt = S_IDLE;
      default:  nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      state <= nxt;
      if (state == S_CLEAR)       cnt <= '0;
      else if (state == S_COMMIT) cnt <= cnt_inc;
    end
  end

  assign rst_a_o    = (state == S_CLEAR);
  assign rst_b_o    = (state == S_CLEAR);
  assign en_a_o     = (state == S_GO) || (state == S_RUN) || (state == S_B_DONE);
  assign en_b_o     = (state == S_GO) || (state == S_RUN) || (state == S_A_DONE);
  assign step_go_o  = (state == S_GO);
  assign commit_o   = (state == S_COMMIT);
  assign run_done_o = (state == S_DONE);
  assign step_cnt_o = cnt;

  p_clear_then_go_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_a_o && step_limit_i != '0) |=> (step_go_o && en_a_o && en_b_o && step_cnt_o == '0));

  p_a_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_a_o && en_b_o && !step_go_o && rdy_a_i && !rdy_b_i) |=> (!en_a_o && en_b_o));

  p_b_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_a_o && en_b_o && !step_go_o && rdy_b_i && !rdy_a_i) |=> (en_a_o && !en_b_o));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_a_o && en_b_o && !rdy_b_i) |=> (!en_a_o && en_b_o && !commit_o && $stable(step_cnt_o)));

  p_both_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_a_o && en_b_o && !step_go_o && rdy_a_i && rdy_b_i) |=> (!en_a_o && !en_b_o && !commit_o));

  p_settle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SETTLE) |=> commit_o);

  p_commit_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |=> !commit_o);

  p_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |=> (step_cnt_o == $past(step_cnt_o) + 1'b1));

  p_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    run_done_o |-> (!en_a_o && !en_b_o && step_cnt_o == step_limit_i));

  p_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rst_a_o, step_go_o, commit_o, run_done_o}));

endmodule

// File: tb/sim_dual_column_sequencer.sv
module sim_dual_column_sequencer;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_i = 1'b0;
  logic [W-1:0] step_limit_i = '0;
  logic rdy_a_i = 1'b0;
  logic rdy_b_i = 1'b0;
  logic rst_a_o, rst_b_o, en_a_o, en_b_o, step_go_o, commit_o, run_done_o;
  logic [W-1:0] step_cnt_o;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  dual_column_sequencer #(.STEP_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .step_limit_i(step_limit_i),
    .rdy_a_i(rdy_a_i), .rdy_b_i(rdy_b_i), .rst_a_o(rst_a_o), .rst_b_o(rst_b_o),
    .en_a_o(en_a_o), .en_b_o(en_b_o), .step_go_o(step_go_o), .commit_o(commit_o),
    .step_cnt_o(step_cnt_o), .run_done_o(run_done_o)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      total = total + 1;
      bad = bad + 1;
      $display("FAIL watchdog: run did not end");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int outs();
    return {rst_a_o, rst_b_o, en_a_o, en_b_o, step_go_o, commit_o, run_done_o};
  endfunction

  // bit order: rst_a rst_b en_a en_b go commit done
  task automatic chk_outs(input int exp, input string req);
    chk(outs() == exp, req, outs(), exp);
  endtask

  task automatic t_reset();
    chk_outs(7'b0000000, "R1 outputs in reset");
    chk(step_cnt_o == 0, "R1 count in reset", step_cnt_o, 0);
    tick();
    tick();
    chk_outs(7'b0000000, "R1 idle with run low");
  endtask

  task automatic t_three_steps();
    step_limit_i = 3;
    run_i = 1'b1;
    tick();
    chk_outs(7'b1100000, "R2 clear cycle");
    chk(step_cnt_o == 0, "R2 count cleared", step_cnt_o, 0);
    tick();
    chk_outs(7'b0011100, "R2 go cycle");
    tick();
    chk_outs(7'b0011000, "R3 both running");
    rdy_a_i = 1'b1;
    tick();
    chk_outs(7'b0001000, "R3 A first drops en_a");
    tick();
    chk_outs(7'b0001000, "R4 holding for B");
    chk(step_cnt_o == 0, "R4 count held", step_cnt_o, 0);
    rdy_b_i = 1'b1;
    tick();
    chk_outs(7'b0000000, "R6 settle cycle");
    rdy_a_i = 1'b0;
    rdy_b_i = 1'b0;
    tick();
    chk_outs(7'b0000010, "R6 commit strobe");
    tick();
    chk_outs(7'b0011100, "R7 next go");
    chk(step_cnt_o == 1, "R7 count after first step", step_cnt_o, 1);
    tick();
    rdy_b_i = 1'b1;
    tick();
    chk_outs(7'b0010000, "R3 B first drops en_b");
    rdy_b_i = 1'b0;
    tick();
    chk_outs(7'b0010000, "R4 holding for A");
    rdy_a_i = 1'b1;
    tick();
    chk_outs(7'b0000000, "R6 settle after B then A");
    rdy_a_i = 1'b0;
    tick();
    chk_outs(7'b0000010, "R6 second commit");
    tick();
    chk(step_cnt_o == 2, "R7 count after second step", step_cnt_o, 2);
    tick();
    rdy_a_i = 1'b1;
    rdy_b_i = 1'b1;
    tick();
    chk_outs(7'b0000000, "R5 same-cycle readies");
    rdy_a_i = 1'b0;
    rdy_b_i = 1'b0;
    tick();
    chk_outs(7'b0000010, "R6 third commit");
    tick();
    chk_outs(7'b0000001, "R8 run done");
    chk(step_cnt_o == 3, "R8 count at limit", step_cnt_o, 3);
    tick();
    chk_outs(7'b0000001, "R8 done held while run high");
    run_i = 1'b0;
    tick();
    chk_outs(7'b0000000, "R8 back to waiting");
  endtask

  task automatic t_zero_limit();
    step_limit_i = 0;
    run_i = 1'b1;
    tick();
    chk_outs(7'b1100000, "R9 clear cycle");
    tick();
    chk_outs(7'b0000001, "R9 done without steps");
    chk(step_cnt_o == 0, "R9 count zero", step_cnt_o, 0);
    run_i = 1'b0;
    tick();
    chk_outs(7'b0000000, "R9 waiting again");
  endtask

  task automatic t_stale_ready();
    step_limit_i = 1;
    run_i = 1'b1;
    tick();
    rdy_a_i = 1'b1;
    tick();
    chk_outs(7'b0011100, "R10 go ignores ready");
    tick();
    chk_outs(7'b0011000, "R10 en_a kept after go");
    tick();
    chk_outs(7'b0001000, "R10 en_a dropped one cycle later");
    rdy_b_i = 1'b1;
    tick();
    rdy_a_i = 1'b0;
    rdy_b_i = 1'b0;
    tick();
    chk_outs(7'b0000010, "R6 commit in single-step run");
    tick();
    chk_outs(7'b0000001, "R8 done after one step");
    chk(step_cnt_o == 1, "R8 count one", step_cnt_o, 1);
    run_i = 1'b0;
    tick();
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_three_steps();
    t_zero_limit();
    t_stale_ready();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule